// File: doc/BRIEF.md
# String Operation Repeat Controller

This block sequences a repeated string operation for a small 16-bit datapath. On a start pulse it captures a source index, a destination index, a repeat counter and the operation settings. It then issues one element access at a time, with read and write request levels toward an external memory, and waits for an element-done handshake. In the cycle that handshake is accepted it steps the indexes, decrements the counter and decides whether another element follows. Five operation kinds are supported: move, load, store, scan and compare. Each works on byte or word elements, and the indexes run upward or downward.

Scan and compare set an equality flag for each element. Under a repeat-while-equal or repeat-while-not-equal setting, that flag can end the sequence before the counter runs out. A load delivers the element to the accumulator through a write strobe. A store, and a move, drive the write data for the destination element. The controller moves through three states. **IDLE** waits for `start`. The transition *launch* leads from IDLE to XFER. The transition *skip* leads from IDLE straight to FIN when a repeated operation starts with a zero count. **XFER** holds the requests until `elem_done`. From XFER, *next* stays in XFER, and *finish* moves to FIN on the last element. **FIN** raises `done` for one cycle, and the transition *retire* returns it to IDLE.

Top module: `strrep_ctrl`

## Requirements
- R1: With `dir_down`=0 each used index increases after an accepted element; with `dir_down`=1 it decreases.
- R2: The index step is 1 for byte elements (`word_mode`=0) and 2 for word elements (`word_mode`=1). A byte element is bits 7:0 of the data buses, with the upper byte driven as zero.
- R3: `op_sel` encodes move=0, load=1, store=2, scan=3 and compare=4. Load steps only the source index, store and scan step only the destination index, and move and compare step both. Load and compare and move request a source read (`rd_src`). Scan and compare request a destination read (`rd_dst`). Move and store request a destination write (`wr_dst`).
- R4: `rep_sel` encodes none=0, while-equal=1, while-not-equal=2 and plain repeat=3. With a nonzero setting the counter decreases by one for each accepted element, and the sequence ends after the element that brings it to zero.
- R5: A repeated operation started with `cnt_init`=0 makes no request, leaves the indexes unchanged, and raises `done` in the cycle after `start`.
- R6: With `rep_sel`=0 exactly one element is processed, whatever the count, and the counter keeps its loaded value.
- R7: Scan compares the accumulator with the destination element, and compare compares the source element with the destination element. `zf` takes the result (1 = equal) on each accepted element; other kinds leave `zf` unchanged.
- R8: Under while-equal, a scan or compare ends after the first element that compares unequal.
- R9: Under while-not-equal, a scan or compare ends after the first element that compares equal.
- R10: `done` is high for exactly one cycle at the end of every sequence, one cycle after the accepting `elem_done`, and `busy` falls in the following cycle.
- R11: Index arithmetic wraps modulo 2^16.
- R12: A load pulses `acc_we` with the source element in the accepting cycle. A store drives the accumulator element on `wr_data`, and a move drives the source element on `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (sampled in IDLE) |
| op_sel | input | 3 | Operation kind |
| word_mode | input | 1 | 1 = word elements, 0 = byte elements |
| dir_down | input | 1 | 1 = indexes decrease |
| rep_sel | input | 2 | Repeat setting |
| src_init | input | 16 | Starting source index |
| dst_init | input | 16 | Starting destination index |
| cnt_init | input | 16 | Starting repeat count |
| acc_in | input | 16 | Accumulator value |
| elem_done | input | 1 | Current element access finished |
| src_rdata | input | 16 | Source element read data |
| dst_rdata | input | 16 | Destination element read data |
| rd_src | output | 1 | Source read request |
| rd_dst | output | 1 | Destination read request |
| wr_dst | output | 1 | Destination write request |
| src_idx | output | 16 | Current source index |
| dst_idx | output | 16 | Current destination index |
| cnt | output | 16 | Current repeat count |
| wr_data | output | 16 | Destination write data |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | 16 | Accumulator write data |
| zf | output | 1 | Equality flag of the last scan/compare element |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A wrong index step or direction shows on `src_idx` or `dst_idx` in the cycle right after the first accepted element. The wrong memory contents that follow become visible when the sequence ends. A faulty counter or termination decision shows as `done` arriving one element early or late, so it is exposed on the cycle of the last element. A stale or inverted equality flag shows on `zf` one cycle after the compare and changes where a while-equal or while-not-equal run stops. The bench model predicts every output each cycle, so the first divergent cycle is reported.

// File: rtl/strrep_pkg.sv
package strrep_pkg;
    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_SCAN  = 3'd3,
        OP_CMP   = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        REP_NONE     = 2'd0,
        REP_WHILE_EQ = 2'd1,
        REP_WHILE_NE = 2'd2,
        REP_ALL      = 2'd3
    } rep_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } state_e;
endpackage

// File: rtl/strrep_fsm.sv
module strrep_fsm
    import strrep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic skip,
    input  logic elem_done,
    input  logic last_elem,
    output logic busy,
    output logic done,
    output logic xfer,
    output logic accept,
    output logic load_cfg
);
    state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = skip ? ST_FIN : ST_XFER;  // launch / skip
            ST_XFER: if (elem_done && last_elem) state_d = ST_FIN;  // finish, else next
            ST_FIN:  state_d = ST_IDLE;                              // retire
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_FIN);
        xfer     = (state_q == ST_XFER);
        accept   = (state_q == ST_XFER) && elem_done;
        load_cfg = (state_q == ST_IDLE) && start;
    end
endmodule

// File: rtl/strrep_regs.sv
module strrep_regs
    import strrep_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_cfg,
    input  logic             accept,
    input  op_e              op_in,
    input  logic             word_in,
    input  logic             dir_in,
    input  rep_e             rep_in,
    input  logic [IDX_W-1:0] src_init,
    input  logic [IDX_W-1:0] dst_init,
    input  logic [IDX_W-1:0] cnt_init,
    input  logic             eq,
    output op_e              op_q,
    output logic             word_q,
    output logic             dir_q,
    output rep_e             rep_q,
    output logic [IDX_W-1:0] src_idx,
    output logic [IDX_W-1:0] dst_idx,
    output logic [IDX_W-1:0] cnt,
    output logic             zf,
    output logic             last_elem
);
    logic [IDX_W-1:0] step, src_nxt, dst_nxt, cnt_nxt;
    logic use_src, use_dst, is_cmp, zf_stop;

    always_comb begin
        step    = word_q ? IDX_W'(LANES) : IDX_W'(1);
        src_nxt = dir_q ? src_idx - step : src_idx + step;
        dst_nxt = dir_q ? dst_idx - step : dst_idx + step;
        cnt_nxt = cnt - IDX_W'(1);
        use_src = (op_q == OP_MOVE) || (op_q == OP_LOAD) || (op_q == OP_CMP);
        use_dst = (op_q != OP_LOAD);
        is_cmp  = (op_q == OP_SCAN) || (op_q == OP_CMP);
        zf_stop = is_cmp && (((rep_q == REP_WHILE_EQ) && !eq) ||
                             ((rep_q == REP_WHILE_NE) && eq));
        last_elem = (rep_q == REP_NONE) || (cnt_nxt == '0) || zf_stop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_MOVE;
            word_q  <= 1'b0;
            dir_q   <= 1'b0;
            rep_q   <= REP_NONE;
            src_idx <= '0;
            dst_idx <= '0;
            cnt     <= '0;
            zf      <= 1'b0;
        end else if (load_cfg) begin
            op_q    <= op_in;
            word_q  <= word_in;
            dir_q   <= dir_in;
            rep_q   <= rep_in;
            src_idx <= src_init;
            dst_idx <= dst_init;
            cnt     <= cnt_init;
        end else if (accept) begin
            if (use_src)           src_idx <= src_nxt;
            if (use_dst)           dst_idx <= dst_nxt;
            if (rep_q != REP_NONE) cnt     <= cnt_nxt;
            if (is_cmp)            zf      <= eq;
        end
    end
endmodule

// File: rtl/strrep_cmp.sv
module strrep_cmp #(
    parameter int DATA_W = 16
) (
    input  logic              word,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic              eq
);
    localparam int LANES = DATA_W / 8;
    logic [LANES-1:0] lane_eq;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_eq[i] = (lhs[8*i +: 8] == rhs[8*i +: 8]);
    end

    assign eq = word ? (&lane_eq) : lane_eq[0];
endmodule

// File: rtl/strrep_ctrl.sv
module strrep_ctrl
    import strrep_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_sel,
    input  logic              word_mode,
    input  logic              dir_down,
    input  logic [1:0]        rep_sel,
    input  logic [IDX_W-1:0]  src_init,
    input  logic [IDX_W-1:0]  dst_init,
    input  logic [IDX_W-1:0]  cnt_init,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              elem_done,
    input  logic [DATA_W-1:0] src_rdata,
    input  logic [DATA_W-1:0] dst_rdata,
    output logic              rd_src,
    output logic              rd_dst,
    output logic              wr_dst,
    output logic [IDX_W-1:0]  src_idx,
    output logic [IDX_W-1:0]  dst_idx,
    output logic [IDX_W-1:0]  cnt,
    output logic [DATA_W-1:0] wr_data,
    output logic              acc_we,
    output logic [DATA_W-1:0] acc_wdata,
    output logic              zf,
    output logic              busy,
    output logic              done
);
    localparam int LANES = DATA_W / 8;

    op_e  op_q;
    rep_e rep_q;
    logic word_q, dir_q, xfer, accept, load_cfg, last_elem, eq, skip;
    logic [DATA_W-1:0] src_elem, acc_elem, dst_elem, cmp_lhs;

    assign skip = (rep_sel != 2'd0) && (cnt_init == '0);

    strrep_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .skip(skip),
        .elem_done(elem_done), .last_elem(last_elem),
        .busy(busy), .done(done), .xfer(xfer), .accept(accept), .load_cfg(load_cfg)
    );

    strrep_regs #(.IDX_W(IDX_W), .LANES(LANES)) u_regs (
        .clk(clk), .rst_n(rst_n), .load_cfg(load_cfg), .accept(accept),
        .op_in(op_e'(op_sel)), .word_in(word_mode), .dir_in(dir_down),
        .rep_in(rep_e'(rep_sel)), .src_init(src_init), .dst_init(dst_init),
        .cnt_init(cnt_init), .eq(eq), .op_q(op_q), .word_q(word_q), .dir_q(dir_q),
        .rep_q(rep_q), .src_idx(src_idx), .dst_idx(dst_idx), .cnt(cnt), .zf(zf),
        .last_elem(last_elem)
    );

    always_comb begin
        src_elem = word_q ? src_rdata : {{(DATA_W-8){1'b0}}, src_rdata[7:0]};
        acc_elem = word_q ? acc_in    : {{(DATA_W-8){1'b0}}, acc_in[7:0]};
        dst_elem = word_q ? dst_rdata : {{(DATA_W-8){1'b0}}, dst_rdata[7:0]};
        cmp_lhs  = (op_q == OP_SCAN) ? acc_elem : src_elem;
    end

    strrep_cmp #(.DATA_W(DATA_W)) u_cmp (
        .word(word_q), .lhs(cmp_lhs), .rhs(dst_elem), .eq(eq)
    );

    always_comb begin
        rd_src    = xfer && ((op_q == OP_MOVE) || (op_q == OP_LOAD) || (op_q == OP_CMP));
        rd_dst    = xfer && ((op_q == OP_SCAN) || (op_q == OP_CMP));
        wr_dst    = xfer && ((op_q == OP_MOVE) || (op_q == OP_STORE));
        wr_data   = (op_q == OP_STORE) ? acc_elem : src_elem;
        acc_we    = accept && (op_q == OP_LOAD);
        acc_wdata = src_elem;
    end
endmodule

// File: rtl/strrep_chk.sv
module strrep_chk
    import strrep_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [1:0]       rep_sel,
    input logic [IDX_W-1:0] cnt_init,
    input logic             busy,
    input logic             done,
    input logic             elem_done,
    input logic [IDX_W-1:0] src_idx,
    input logic [IDX_W-1:0] dst_idx,
    input logic [IDX_W-1:0] cnt,
    input logic             rd_src,
    input logic             acc_we,
    input op_e              op_q,
    input rep_e             rep_q,
    input logic             dir_q,
    input logic             word_q
);
    logic acc_cyc;
    assign acc_cyc = busy && !done && elem_done;

    // R10
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && rep_sel != 2'd0 && cnt_init == '0) |=> (done && !rd_src));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cyc && rep_q != REP_NONE) |=> (cnt == $past(cnt) - IDX_W'(1)));

    // R6
    single_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cyc && rep_q == REP_NONE) |=> (done && $stable(cnt)));

    // R3
    load_dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cyc && op_q == OP_LOAD) |=> $stable(dst_idx));

    // R1
    src_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cyc && rd_src && !dir_q && !word_q) |=> (src_idx == $past(src_idx) + IDX_W'(1)));

    // R12
    acc_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> (busy && !done && rd_src && op_q == OP_LOAD));
endmodule

bind strrep_ctrl strrep_chk #(.IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rep_sel(rep_sel), .cnt_init(cnt_init),
    .busy(busy), .done(done), .elem_done(elem_done), .src_idx(src_idx),
    .dst_idx(dst_idx), .cnt(cnt), .rd_src(rd_src), .acc_we(acc_we),
    .op_q(op_q), .rep_q(rep_q), .dir_q(dir_q), .word_q(word_q)
);

// File: tb/strrep_ctrl_tb.sv
module strrep_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic word_mode = 1'b0, dir_down = 1'b0;
    logic [1:0] rep_sel = 2'd0;
    logic [15:0] src_init = '0, dst_init = '0, cnt_init = '0;
    logic [15:0] acc_reg = '0;
    logic elem_done = 1'b0;
    logic [15:0] src_rdata, dst_rdata;
    logic rd_src, rd_dst, wr_dst, acc_we, zf, busy, done;
    logic [15:0] src_idx, dst_idx, cnt, wr_data, acc_wdata;

    logic [7:0] dmem [256];
    logic [7:0] emem [256];

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // reference model state
    int m_ph = 0;
    int m_op = 0, m_rep = 0;
    bit m_word = 0, m_dir = 0, m_zf = 0;
    logic [15:0] m_src = 0, m_dst = 0, m_cnt = 0, m_acc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strrep_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .word_mode(word_mode),
        .dir_down(dir_down), .rep_sel(rep_sel), .src_init(src_init), .dst_init(dst_init),
        .cnt_init(cnt_init), .acc_in(acc_reg), .elem_done(elem_done),
        .src_rdata(src_rdata), .dst_rdata(dst_rdata), .rd_src(rd_src), .rd_dst(rd_dst),
        .wr_dst(wr_dst), .src_idx(src_idx), .dst_idx(dst_idx), .cnt(cnt),
        .wr_data(wr_data), .acc_we(acc_we), .acc_wdata(acc_wdata), .zf(zf),
        .busy(busy), .done(done)
    );

    function automatic logic [15:0] rd16(input logic [7:0] m [256], input logic [15:0] a);
        return {m[8'(a + 16'd1)], m[a[7:0]]};
    endfunction

    assign src_rdata = rd16(dmem, src_idx);
    assign dst_rdata = rd16(dmem, dst_idx);

    always @(posedge clk) begin
        if (wr_dst && elem_done && busy && !done) begin
            dmem[dst_idx[7:0]] <= wr_data[7:0];
            if (m_word) dmem[8'(dst_idx + 16'd1)] <= wr_data[15:8];
        end
        if (acc_we) acc_reg <= acc_wdata;
    end

    // reference model: behaviour from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_src = 0; m_dst = 0; m_cnt = 0; m_zf = 0;
            m_op = 0; m_rep = 0; m_word = 0; m_dir = 0;
        end else begin
            case (m_ph)
                0: if (start) begin
                    m_op = op_sel; m_rep = rep_sel; m_word = word_mode; m_dir = dir_down;
                    m_src = src_init; m_dst = dst_init; m_cnt = cnt_init;
                    m_ph = (m_rep != 0 && m_cnt == 0) ? 2 : 1;
                end
                1: if (elem_done) begin
                    logic [15:0] mask, s, d, a, stp;
                    bit eq, stop;
                    mask = m_word ? 16'hFFFF : 16'h00FF;
                    s = rd16(emem, m_src) & mask;
                    d = rd16(emem, m_dst) & mask;
                    a = m_acc & mask;
                    stp = m_word ? 16'd2 : 16'd1;
                    eq = (m_op == 3) ? (a == d) : (s == d);
                    if (m_op == 0 || m_op == 2) begin
                        logic [15:0] v;
                        v = (m_op == 0) ? s : a;
                        emem[m_dst[7:0]] = v[7:0];
                        if (m_word) emem[8'(m_dst + 16'd1)] = v[15:8];
                    end
                    if (m_op == 1) m_acc = s;
                    if (m_op == 0 || m_op == 1 || m_op == 4) m_src = m_dir ? m_src - stp : m_src + stp;
                    if (m_op != 1) m_dst = m_dir ? m_dst - stp : m_dst + stp;
                    if (m_rep != 0) m_cnt = m_cnt - 16'd1;
                    if (m_op == 3 || m_op == 4) m_zf = eq;
                    stop = (m_rep == 0) || (m_cnt == 0) ||
                           ((m_op == 3 || m_op == 4) && ((m_rep == 1 && !eq) || (m_rep == 2 && eq)));
                    m_ph = stop ? 2 : 1;
                end
                default: m_ph = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            bit in_x;
            in_x = (m_ph == 1);
            chk("R10 busy", 32'(busy), 32'(m_ph != 0));
            chk("R5 R10 done", 32'(done), 32'(m_ph == 2));
            chk("R1 R2 R3 R11 src_idx", 32'(src_idx), 32'(m_src));
            chk("R1 R2 R3 R11 dst_idx", 32'(dst_idx), 32'(m_dst));
            chk("R4 R6 cnt", 32'(cnt), 32'(m_cnt));
            chk("R7 R8 R9 zf", 32'(zf), 32'(m_zf));
            chk("R3 rd_src", 32'(rd_src), 32'(in_x && (m_op == 0 || m_op == 1 || m_op == 4)));
            chk("R3 rd_dst", 32'(rd_dst), 32'(in_x && (m_op == 3 || m_op == 4)));
            chk("R3 wr_dst", 32'(wr_dst), 32'(in_x && (m_op == 0 || m_op == 2)));
            chk("R12 accumulator", 32'(acc_reg), 32'(m_acc));
        end
    end

    always @(negedge clk) begin
        #1;
        elem_done = (rd_src || rd_dst || wr_dst) && ($urandom_range(0, 2) != 0);
    end

    task automatic run(input int op, input bit w, input bit dn, input int rp,
                       input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                       input string tag);
        int wait_cyc;
        @(negedge clk); #2;
        op_sel = 3'(op); word_mode = w; dir_down = dn; rep_sel = 2'(rp);
        src_init = s; dst_init = d; cnt_init = c; start = 1'b1;
        @(negedge clk); #2;
        start = 1'b0;
        wait_cyc = 0;
        while (m_ph != 0 && wait_cyc < 500) begin @(negedge clk); wait_cyc++; end
        @(negedge clk);
        begin
            int diff;
            diff = 0;
            for (int i = 0; i < 256; i++) if (dmem[i] !== emem[i]) diff++;
            chk({tag, " memory"}, 32'(diff), 32'd0);
        end
    endtask

    task automatic set_acc(input logic [15:0] v);
        @(negedge clk); #2;
        acc_reg = v; m_acc = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            dmem[i] = 8'(i * 7 + 3);
            emem[i] = 8'(i * 7 + 3);
        end
        for (int i = 0; i < 8; i++) begin
            dmem[8'h60 + i] = 8'(i + 8'h40); emem[8'h60 + i] = 8'(i + 8'h40);
            dmem[8'h70 + i] = 8'(i + 8'h40); emem[8'h70 + i] = 8'(i + 8'h40);
        end
        dmem[8'h65] = 8'hEE; emem[8'h65] = 8'hEE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 R2 R3 R4: word move upward
        run(0, 1, 0, 3, 16'h0010, 16'h0080, 16'd4, "R1 R2 R4 move word up");
        // R1 R2: byte move downward
        run(0, 0, 1, 3, 16'h0030, 16'h00A0, 16'd3, "R1 R2 move byte down");
        // R6 R12: single load ignores count
        run(1, 0, 0, 0, 16'h0005, 16'h0000, 16'd5, "R6 R12 load single");
        // R12: word store downward
        set_acc(16'hBEEF);
        run(2, 1, 1, 3, 16'h0000, 16'h00C0, 16'd2, "R12 store word");
        // R9: scan until match
        set_acc(16'h00 + 8'(3 * 7 + 3) + 16'h1200);
        run(3, 0, 0, 2, 16'h0000, 16'h0000, 16'd10, "R7 R9 scan ne");
        // R8: compare while equal, stops at mismatch
        run(4, 1, 0, 1, 16'h0060, 16'h0070, 16'd4, "R7 R8 compare eq");
        // R8: count runs out before mismatch
        run(4, 0, 0, 1, 16'h0060, 16'h0070, 16'd3, "R8 compare exhaust");
        // R5: zero count repeated
        run(0, 1, 0, 3, 16'h0010, 16'h0090, 16'd0, "R5 zero count");
        // R6: zero count, no repeat, one element
        run(2, 0, 0, 0, 16'h0000, 16'h00D0, 16'd0, "R6 no repeat zero");
        // R11: wrap below zero
        run(1, 1, 1, 3, 16'h0000, 16'h0000, 16'd2, "R11 wrap load");
        // R7: single scan word
        set_acc(16'h1234);
        run(3, 1, 0, 0, 16'h0000, 16'h0040, 16'd7, "R7 scan single");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule